// File: doc/BRIEF.md
# Serial Flash Program and Erase Engine

This block is the write side of a small on-chip flash array behind a serial command front end. The front end has already decoded each command. It hands this engine a one-cycle request that carries an operation code and a 24-bit byte address. For a page program, a stream of data bytes follows, and an end strobe closes it. A separate write-enable pulse arms the engine. Each accepted program or erase clears that arming, so every modifying command needs a fresh enable. A registered read port exposes the array contents to the surrounding logic.

Control is one state machine with four named states:

- `ST_IDLE` waits for a request.
- `ST_COLLECT` gathers program data into a page-sized staging buffer.
- `ST_PROG` commits that buffer into the array.
- `ST_ERASE` fills a sector, or the whole array, with ones.

It has five named transitions:

- `ST_IDLE` to `ST_COLLECT` on an accepted program.
- `ST_IDLE` to `ST_ERASE` on an accepted sector or bulk erase.
- `ST_COLLECT` to `ST_PROG` on the end strobe.
- `ST_PROG` to `ST_IDLE` on the last timed cycle.
- `ST_ERASE` to `ST_IDLE` on the last timed cycle.

The busy output is high exactly while the engine sits in `ST_PROG` or `ST_ERASE`. Each cycle length is a parameter counted in clock cycles. A length shorter than the number of bytes the operation touches is raised to that byte count.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, busy_o and wel_o are both 0.
- R2: A one-cycle pulse on wren_i makes wel_o read 1 from the next cycle on. It stays 1 until an operation is accepted.
- R3: A request made while wel_o is 0 is ignored. busy_o stays 0 and no array byte changes, even if data bytes and an end strobe follow.
- R4: Operation code 2'b01 is a page program. Data bytes arrive with byte_valid_i, and data_end_i closes the stream; it may coincide with the last byte. The first byte lands at the offset given by the low 8 address bits, inside the 256-byte page that holds the address. Later bytes take consecutive offsets. Each target byte becomes its old value ANDed with the new byte, and every other byte keeps its value.
- R5: A program stream that passes offset 255 wraps to offset 0 of the same page. When more than 256 bytes arrive, only the last 256 bytes take effect.
- R6: Operation code 2'b10 is a sector erase. It sets every byte of the sector that holds the address to 8'hFF, and leaves all other sectors unchanged.
- R7: Operation code 2'b11 is a bulk erase. It sets every byte of the array to 8'hFF.
- R8: busy_o rises in the cycle after the accepting edge of an erase, or after the edge that samples data_end_i for a program. It then stays high for exactly T_SE, T_BE or T_PP cycles.
- R9: A request made while busy_o is 1, or while program data is being collected, is ignored. The running operation completes unchanged, and wel_o is not cleared by the ignored request.
- R10: wel_o reads 0 in the cycle after an operation is accepted.
- R11: Operation code 2'b00 is no operation. It starts nothing, and wel_o keeps its value.
- R12: rd_data_o shows the array byte at rd_addr_i as sampled on the previous clock edge. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wren_i | input | 1 | Write-enable pulse |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_op_i | input | 2 | Operation code: 00 none, 01 program, 10 sector erase, 11 bulk erase |
| req_addr_i | input | 24 | Byte address of the request |
| byte_valid_i | input | 1 | Program data byte strobe |
| byte_i | input | 8 | Program data byte |
| data_end_i | input | 1 | End of program data stream |
| rd_addr_i | input | 24 | Read address; high bits above the array size are ignored |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | Internal program or erase cycle in progress |
| wel_o | output | 1 | Write-enable latch |

## Verification
A state machine stuck outside `ST_IDLE` shows up at once. busy_o stays high past the parameter count, or later requests stop taking effect; the bench measures every busy window to the exact cycle. A wrong staging pointer or mask shows no symptom until the commit ends, and then it appears as misplaced or unmasked bytes. The bench reads the whole array back against its own model after each operation, so a single-byte slip is reported within one read-back pass. A latch that fails to clear shows one cycle after acceptance as wel_o still set, or later as a request that should have been rejected but took effect.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_BULK = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_PROG,
        ST_ERASE
    } state_e;

    typedef enum logic [1:0] {
        WM_NONE,
        WM_AND,
        WM_FILL
    } wmode_e;

endpackage

// File: rtl/flash_pe_wel.sv
module flash_pe_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
        end else if (clr_i) begin
            wel_o <= 1'b0;
        end else if (set_i) begin
            wel_o <= 1'b1;
        end
    end

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> wel_o);

endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             active_o,
    output logic             last_o,
    output logic [CNT_W-1:0] idx_o
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            remain_q <= '0;
            idx_o    <= '0;
        end else if (load_i) begin
            active_o <= 1'b1;
            remain_q <= val_i - 1'b1;
            idx_o    <= '0;
        end else if (active_o) begin
            if (remain_q == '0) begin
                active_o <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
                idx_o    <= idx_o + 1'b1;
            end
        end
    end

    assign last_o = active_o && (remain_q == '0);

    // R8
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o && !load_i) |=> (active_o && idx_o == $past(idx_o) + 1'b1));

endmodule

// File: rtl/flash_pe_pagebuf.sv
module flash_pe_pagebuf #(
    parameter int PAGE_BYTES = 256,
    localparam int PAGE_AW   = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic [PAGE_AW-1:0] start_i,
    input  logic               wr_i,
    input  logic [7:0]         data_i,
    input  logic [PAGE_AW-1:0] rd_idx_i,
    output logic [7:0]         rd_data_o
);

    logic [7:0]            buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [PAGE_AW-1:0]    ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ptr_q  <= '0;
        end else if (clear_i) begin
            mask_q <= '0;
            ptr_q  <= start_i;
        end else if (wr_i) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i && !clear_i) begin
            buf_q[ptr_q] <= data_i;
        end
    end

    assign rd_data_o = mask_q[rd_idx_i] ? buf_q[rd_idx_i] : 8'hFF;

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i && ptr_q == '1) |=> (ptr_q == '0));

    // R4
    byte_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i) |=> mask_q[$past(ptr_q)]);

endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  wmode_e        wmode_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        unique case (wmode_i)
            WM_AND:  mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
            WM_FILL: mem_q[waddr_i] <= 8'hFF;
            default: ;
        endcase
        rdata_o <= mem_q[raddr_i];
    end

    // R3
    write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wmode_i != WM_NONE) |-> busy_i);

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_PAGES = 4,
    parameter int NUM_SECTORS  = 2,
    parameter int T_PP         = 300,
    parameter int T_SE         = 1100,
    parameter int T_BE         = 2100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wren_i,
    input  logic        req_valid_i,
    input  logic [1:0]  req_op_i,
    input  logic [23:0] req_addr_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    input  logic        data_end_i,
    input  logic [23:0] rd_addr_i,
    output logic [7:0]  rd_data_o,
    output logic        busy_o,
    output logic        wel_o
);

    localparam int SECTOR_BYTES = SECTOR_PAGES * PAGE_BYTES;
    localparam int ARRAY_BYTES  = NUM_SECTORS * SECTOR_BYTES;
    localparam int MEM_AW       = $clog2(ARRAY_BYTES);
    localparam int PAGE_AW      = $clog2(PAGE_BYTES);
    localparam int EFF_PP       = (T_PP > PAGE_BYTES)   ? T_PP : PAGE_BYTES;
    localparam int EFF_SE       = (T_SE > SECTOR_BYTES) ? T_SE : SECTOR_BYTES;
    localparam int EFF_BE       = (T_BE > ARRAY_BYTES)  ? T_BE : ARRAY_BYTES;
    localparam int T_MAX_A      = (EFF_PP > EFF_SE) ? EFF_PP : EFF_SE;
    localparam int T_MAX        = (T_MAX_A > EFF_BE) ? T_MAX_A : EFF_BE;
    localparam int CNT_W        = $clog2(T_MAX + 1);

    state_e              state_q, state_d;
    op_e                 req_op;
    logic                accept;
    logic [MEM_AW-1:0]   base_q;
    logic [CNT_W-1:0]    span_q;
    logic                pb_clear, pb_wr;
    logic [7:0]          pb_rd_data;
    logic                tm_load, tm_active, tm_last;
    logic [CNT_W-1:0]    tm_val, tm_idx;
    logic                in_span;
    wmode_e              wmode;
    logic [MEM_AW-1:0]   waddr;
    logic                wel_set, wel_clr;

    assign req_op  = op_e'(req_op_i);
    assign accept  = (state_q == ST_IDLE) && req_valid_i && wel_o && (req_op != OP_NONE);
    assign in_span = tm_idx < span_q;
    assign waddr   = base_q + tm_idx[MEM_AW-1:0];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (req_op == OP_PROG) ? ST_COLLECT : ST_ERASE;
                end
            end
            ST_COLLECT: begin
                if (data_end_i) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (tm_last) state_d = ST_IDLE;
            end
            ST_ERASE: begin
                if (tm_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Region captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            span_q <= '0;
        end else if (accept) begin
            unique case (req_op)
                OP_PROG: begin
                    base_q <= req_addr_i[MEM_AW-1:0] & ~MEM_AW'(PAGE_BYTES - 1);
                    span_q <= CNT_W'(PAGE_BYTES);
                end
                OP_SECT: begin
                    base_q <= req_addr_i[MEM_AW-1:0] & ~MEM_AW'(SECTOR_BYTES - 1);
                    span_q <= CNT_W'(SECTOR_BYTES);
                end
                default: begin
                    base_q <= '0;
                    span_q <= CNT_W'(ARRAY_BYTES);
                end
            endcase
        end
    end

    // Outputs per state
    always_comb begin
        busy_o   = (state_q == ST_PROG) || (state_q == ST_ERASE);
        pb_clear = 1'b0;
        pb_wr    = 1'b0;
        tm_load  = 1'b0;
        tm_val   = '0;
        wmode    = WM_NONE;
        wel_set  = wren_i;
        wel_clr  = accept;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_op == OP_PROG) begin
                        pb_clear = 1'b1;
                    end else begin
                        tm_load = 1'b1;
                        tm_val  = (req_op == OP_SECT) ? CNT_W'(EFF_SE) : CNT_W'(EFF_BE);
                    end
                end
            end
            ST_COLLECT: begin
                pb_wr = byte_valid_i;
                if (data_end_i) begin
                    tm_load = 1'b1;
                    tm_val  = CNT_W'(EFF_PP);
                end
            end
            ST_PROG: begin
                if (in_span) wmode = WM_AND;
            end
            ST_ERASE: begin
                if (in_span) wmode = WM_FILL;
            end
            default: ;
        endcase
    end

    flash_pe_wel u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wel_set),
        .clr_i (wel_clr),
        .wel_o (wel_o)
    );

    flash_pe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tm_load),
        .val_i    (tm_val),
        .active_o (tm_active),
        .last_o   (tm_last),
        .idx_o    (tm_idx)
    );

    flash_pe_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pagebuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (pb_clear),
        .start_i   (req_addr_i[PAGE_AW-1:0]),
        .wr_i      (pb_wr),
        .data_i    (byte_i),
        .rd_idx_i  (tm_idx[PAGE_AW-1:0]),
        .rd_data_o (pb_rd_data)
    );

    flash_pe_array #(.DEPTH(ARRAY_BYTES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_o),
        .wmode_i (wmode),
        .waddr_i (waddr),
        .wdata_i (pb_rd_data),
        .raddr_i (rd_addr_i[MEM_AW-1:0]),
        .rdata_o (rd_data_o)
    );

    // R10
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !wel_o);

    // R3
    entry_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) == ST_IDLE) |-> $past(wel_o));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tm_last) |=> busy_o);

    // R8
    busy_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> tm_active);

endmodule

// File: tb/flash_pe_engine_test.sv
module flash_pe_engine_test;

    localparam int PB   = 256;
    localparam int SP   = 2;
    localparam int NS   = 2;
    localparam int AB   = PB * SP * NS;
    localparam int TPP  = 300;
    localparam int TSE  = 600;
    localparam int TBE  = 1100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_op_i = 2'b00;
    logic [23:0] req_addr_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        data_end_i = 1'b0;
    logic [23:0] rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        busy_o;
    logic        wel_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [AB];

    always #4 clk = ~clk;

    flash_pe_engine #(
        .PAGE_BYTES(PB), .SECTOR_PAGES(SP), .NUM_SECTORS(NS),
        .T_PP(TPP), .T_SE(TSE), .T_BE(TBE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .req_valid_i(req_valid_i),
        .req_op_i(req_op_i), .req_addr_i(req_addr_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .data_end_i(data_end_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .wel_o(wel_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_wren();
        wren_i = 1'b1; tick(); wren_i = 1'b0;
    endtask

    task automatic send_req(input logic [1:0] op, input logic [23:0] addr);
        req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr;
        tick();
        req_valid_i = 1'b0; req_op_i = 2'b00;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid_i = 1'b1; byte_i = b; tick(); byte_valid_i = 1'b0;
    endtask

    task automatic send_end();
        data_end_i = 1'b1; tick(); data_end_i = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_o && n < 5000) begin
            n++;
            tick();
        end
    endtask

    task automatic read_byte(input logic [23:0] addr, output logic [7:0] d);
        rd_addr_i = addr; tick(); d = rd_data_o;
    endtask

    task automatic cmp_all(input string tag);
        int mism = 0;
        logic [7:0] d;
        for (int a = 0; a < AB; a++) begin
            read_byte(24'(a), d);
            if (d !== exp_mem[a]) mism++;
        end
        chk(tag, mism, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", busy_o, 0);
        chk("R1 wel after reset", wel_o, 0);
    endtask

    task automatic t_wren();
        pulse_wren();
        chk("R2 wel set", wel_o, 1);
    endtask

    task automatic t_bulk();
        int n;
        send_req(2'b11, 24'h000100);
        chk("R10 wel cleared bulk", wel_o, 0);
        count_busy(n);
        chk("R8 bulk busy length", n, TBE);
        for (int a = 0; a < AB; a++) exp_mem[a] = 8'hFF;
        cmp_all("R7 bulk erase");
    endtask

    task automatic t_nowel();
        send_req(2'b01, 24'h000110);
        chk("R3 no busy without wel", busy_o, 0);
        send_byte(8'h00); send_byte(8'h00); send_end();
        chk("R3 still idle", busy_o, 0);
        cmp_all("R3 array unchanged");
    endtask

    task automatic t_program();
        int n;
        logic [7:0] d;
        pulse_wren();
        send_req(2'b01, 24'h000110);
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hF0);
        send_end();
        count_busy(n);
        chk("R8 program busy length", n, TPP);
        exp_mem[16'h110] &= 8'hA5; exp_mem[16'h111] &= 8'h3C; exp_mem[16'h112] &= 8'hF0;
        cmp_all("R4 first program");
        pulse_wren();
        send_req(2'b01, 24'h000111);
        send_byte(8'h0F);
        byte_valid_i = 1'b1; byte_i = 8'hFF; data_end_i = 1'b1;
        tick();
        byte_valid_i = 1'b0; data_end_i = 1'b0;
        count_busy(n);
        exp_mem[16'h111] &= 8'h0F; exp_mem[16'h112] &= 8'hFF;
        cmp_all("R4 AND program with end on last byte");
        read_byte(24'h000111, d);
        chk("R12 read after program", d, 8'h0C);
    endtask

    task automatic t_wrap();
        int n;
        logic [7:0] d;
        logic [7:0] pg [PB];
        for (int k = 0; k < PB; k++) pg[k] = 8'hFF;
        pulse_wren();
        send_req(2'b01, 24'h0002FE);
        for (int i = 0; i < 260; i++) begin
            send_byte(8'(i * 7 + 3));
            pg[(8'hFE + i) % PB] = 8'(i * 7 + 3);
        end
        send_end();
        count_busy(n);
        for (int k = 0; k < PB; k++) exp_mem[16'h200 + k] &= pg[k];
        cmp_all("R5 wrap page");
        read_byte(24'h0002FE, d);
        chk("R5 last writer at start offset", d, 8'h03);
        read_byte(24'h000200, d);
        chk("R5 wrapped byte at offset 0", d, 8'h11);
    endtask

    task automatic t_sector();
        int n;
        pulse_wren();
        send_req(2'b10, 24'h0002A0);
        chk("R10 wel cleared sector", wel_o, 0);
        count_busy(n);
        chk("R8 sector busy length", n, TSE);
        for (int a = 16'h200; a < 16'h400; a++) exp_mem[a] = 8'hFF;
        cmp_all("R6 sector erase");
    endtask

    task automatic t_busy_ignore();
        int n;
        pulse_wren();
        send_req(2'b10, 24'h0003F0);
        repeat (5) tick();
        pulse_wren();
        send_req(2'b11, 24'h000000);
        count_busy(n);
        chk("R9 busy length unaffected", n + 7, TSE);
        chk("R9 wel kept after ignored request", wel_o, 1);
        cmp_all("R9 bulk during busy ignored");
        send_req(2'b01, 24'h000180);
        send_byte(8'h55);
        pulse_wren();
        send_req(2'b10, 24'h000000);
        send_byte(8'hAA);
        send_end();
        count_busy(n);
        chk("R9 program not replaced during collect", n, TPP);
        exp_mem[16'h180] &= 8'h55; exp_mem[16'h181] &= 8'hAA;
        cmp_all("R9 erase during collect ignored");
        chk("R9 wel kept during collect", wel_o, 1);
    endtask

    task automatic t_opnone();
        send_req(2'b00, 24'h000000);
        chk("R11 no busy for op none", busy_o, 0);
        tick();
        chk("R11 wel kept", wel_o, 1);
        cmp_all("R11 array unchanged");
    endtask

    task automatic t_read_latency();
        logic [7:0] d;
        read_byte(24'h000110, d);
        chk("R12 read value", d, exp_mem[16'h110]);
        rd_addr_i = 24'h000181;
        #1;
        chk("R12 holds between edges", rd_data_o, exp_mem[16'h110]);
        tick();
        chk("R12 next address", rd_data_o, exp_mem[16'h181]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wren();
        t_bulk();
        t_nowel();
        t_program();
        t_wrap();
        t_sector();
        t_busy_ignore();
        t_opnone();
        t_read_latency();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule